// File: doc/BRIEF.md
# Long-Press Enable Shutdown Supervisor

This block supervises a power-management unit's on/off sequencing from two sources: a host processor and a physical enable line. The host keeps the supply alive by holding a power-hold input high and requests a shutdown by dropping it while the low-power request is also low. A user can force the supply down by holding the enable line low. After a programmable enable timeout, a non-maskable active-low interrupt is raised and a status flag is set. The host then has a programmable response window to read the status word. That read clears the flag and releases the interrupt. If the host stays silent, the block shuts down by itself.

Every shutdown follows the same order. The active-low reset output goes low first, and the regulator channel enables drop one cycle later. At that point each channel's discharge output turns on, but only if discharge is configured for that channel. Start-up begins only on a fresh rising edge of the enable line. It passes through a start-up wait, in which the host must assert power-hold within a parameterized number of ticks. All timers count a millisecond tick input, so the block can be run with an accelerated tick.

Top module: `lp_shutdown_ctrl`

## Requirements
- R1: During and after reset the block is off: `rst_out_n`=0, `ch_en`=0, `irq_n`=1, status word all zero, and `ch_dis` equals `dis_cfg`.
- R2: In the off state, a rising edge on `pwr_en` (low at one clock edge, high at the next) enters start-up wait one cycle later, with all channels enabled and `rst_out_n`=1. A `pwr_en` that is already high at reset is not an edge.
- R3: In start-up wait, `hold_in`=1 moves the block to on. If `STARTUP_MS` ticks pass without power-hold, a shutdown starts: `rst_out_n` goes low after the edge that counts the last tick. Power-hold being low has no other effect in this state.
- R4: When on, `hold_in`=0 together with `lpm_in`=0 drives `rst_out_n` low after the next edge. The channel enables drop one edge later. While `lpm_in`=1, a low `hold_in` does nothing.
- R5: While the block is in start-up wait or on, `pwr_en` low at each of N consecutive tick edges, where N is the enable timeout, drives `irq_n` low and status bit 5 high on the same cycle.
- R6: The enable timeout code `t8_sel` selects 00=0 ms (fires on the first tick), 01=4000 ms, 10=2000 ms and 11=8000 ms. A clock edge that sees `pwr_en` high restarts the count.
- R7: A `stat_rd` strobe while the interrupt is pending clears status bit 5 and releases `irq_n` after that edge, and resets both timeouts. If `pwr_en` is still low, the enable timeout then counts again from zero. If `pwr_en` is high, operation continues with no shutdown.
- R8: The response timeout code `t9_sel` selects 00=100 ms, 01=500 ms, 10=1000 ms and 11=2000 ms. That many tick edges after the interrupt asserts with no read, `rst_out_n` goes low and the shutdown order of R4 follows.
- R9: If the response timeout expires during start-up wait, the start-up timer is abandoned and the block shuts down to off.
- R10: Whenever channels are enabled, `ch_dis` is zero. In the off state, `ch_dis[i]` equals `dis_cfg[i]`.
- R11: Once off, the block stays off regardless of `hold_in` or a steady `pwr_en` level, until a new rising edge of `pwr_en`.
- R12: A `stat_rd` strobe on the same edge as response-timeout expiry takes priority, and no shutdown occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_en | input | 1 | Enable line; high = enabled, held low = long press |
| hold_in | input | 1 | Host power-hold request |
| lpm_in | input | 1 | Host low-power request; high blocks host shutdown |
| tick_ms | input | 1 | One-cycle millisecond tick |
| stat_rd | input | 1 | Status word read strobe (reset-on-read) |
| t8_sel | input | 2 | Enable timeout code |
| t9_sel | input | 2 | Response timeout code |
| dis_cfg | input | NCH | Per-channel discharge enable configuration |
| irq_n | output | 1 | Active-low long-press interrupt |
| stat_word | output | STAT_W | Status word, long-press flag at bit STAT_BIT (5) |
| rst_out_n | output | 1 | Active-low system reset output |
| ch_en | output | NCH | Regulator channel enables |
| ch_dis | output | NCH | Channel active-discharge enables |

## Verification
Some properties are checked on every cycle: the reset output always falls before the channels switch off, discharge never overlaps an enabled channel and follows its configuration when off, an acknowledged interrupt is released one cycle later, the interrupt only falls after the enable line was low, and channels only switch on after a rising enable edge. The exact tick counts of each timeout code cannot be shown by a per-cycle property. Neither can the restart of the enable count after an acknowledgement, the priority of a read over expiry, the abandoned start-up wait, or the low-power blocking of host shutdown. The bench's scenarios show these by sampling one cycle before and one cycle at each boundary.

// File: rtl/lpsd_pkg.sv
// Package: shared state type and timeout code decoding for the
// long-press shutdown supervisor. Assumes a 1 ms tick time base.
package lpsd_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_ON   = 2'd2,
        ST_SHUT = 2'd3
    } sup_state_t;

    localparam int TMR_W = 14;

    // Enable timeout in ticks; code 01 is the 4 s default.
    function automatic logic [TMR_W-1:0] enable_limit(input logic [1:0] code);
        case (code)
            2'b00:   return TMR_W'(0);
            2'b01:   return TMR_W'(4000);
            2'b10:   return TMR_W'(2000);
            default: return TMR_W'(8000);
        endcase
    endfunction

    // Host response timeout in ticks; code 01 is the 500 ms default.
    function automatic logic [TMR_W-1:0] response_limit(input logic [1:0] code);
        case (code)
            2'b00:   return TMR_W'(100);
            2'b01:   return TMR_W'(500);
            2'b10:   return TMR_W'(1000);
            default: return TMR_W'(2000);
        endcase
    endfunction

endpackage

// File: rtl/lpsd_timeout_sel.sv
// Decodes the two timeout select codes into tick limits.
// Assumes the codes are static or change only between presses.
module lpsd_timeout_sel
    import lpsd_pkg::*;
(
    input  logic [1:0]       t8_sel,
    input  logic [1:0]       t9_sel,
    output logic [TMR_W-1:0] lim_press,
    output logic [TMR_W-1:0] lim_resp
);

    // Purpose: map each code to its tick count.
    always_comb begin
        lim_press = enable_limit(t8_sel);
        lim_resp  = response_limit(t9_sel);
    end

endmodule

// File: rtl/lpsd_press_mon.sv
// Long-press monitor: counts ticks while the enable line is low, raises a
// pending flag at the enable limit, then counts the host response window.
// A read strobe clears the flag and both counts. Assumes 'active' is low
// whenever the supervisor is off or shutting down; that clears all state.
module lpsd_press_mon
    import lpsd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             en_lvl,
    input  logic             tick,
    input  logic             ack_rd,
    input  logic [TMR_W-1:0] lim_press,
    input  logic [TMR_W-1:0] lim_resp,
    output logic             pend,
    output logic             expire
);

    logic [TMR_W-1:0] press_cnt;
    logic [TMR_W-1:0] resp_cnt;
    logic [TMR_W-1:0] press_nxt;
    logic [TMR_W-1:0] resp_nxt;

    // Purpose: next counter values.
    always_comb begin
        press_nxt = press_cnt + 1'b1;
        resp_nxt  = resp_cnt + 1'b1;
    end

    // Purpose: response window ends on this tick unless the host reads now.
    assign expire = pend && tick && !ack_rd && (resp_nxt >= lim_resp);

    // Purpose: press counting, flag raise, acknowledgement and window counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            press_cnt <= '0;
            resp_cnt  <= '0;
        end else if (!active) begin
            pend      <= 1'b0;
            press_cnt <= '0;
            resp_cnt  <= '0;
        end else if (pend) begin
            if (ack_rd) begin
                pend      <= 1'b0;
                press_cnt <= '0;
                resp_cnt  <= '0;
            end else if (tick && !expire) begin
                resp_cnt <= resp_nxt;
            end
        end else if (en_lvl) begin
            press_cnt <= '0;
        end else if (tick) begin
            if (press_nxt >= lim_press) begin
                pend      <= 1'b1;
                press_cnt <= '0;
                resp_cnt  <= '0;
            end else begin
                press_cnt <= press_nxt;
            end
        end
    end

endmodule

// File: rtl/lpsd_seq_fsm.sv
// Supervisor sequencer: off -> start-up wait -> on, and a one-cycle
// shutdown state that asserts reset before the channels drop.
// Assumes the enable line is synchronous to clk.
module lpsd_seq_fsm
    import lpsd_pkg::*;
#(
    parameter int STARTUP_MS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_lvl,
    input  logic       hold,
    input  logic       lpm,
    input  logic       tick,
    input  logic       expire,
    output sup_state_t state
);

    localparam int WCW = $clog2(STARTUP_MS + 1);
    localparam logic [WCW-1:0] WAIT_LIM = WCW'(STARTUP_MS);

    logic           en_q;
    logic           en_rise;
    logic [WCW-1:0] wait_cnt;
    logic [WCW-1:0] wait_nxt;

    // Purpose: rising edge of the enable line and start-up count increment.
    always_comb begin
        en_rise  = en_lvl && !en_q;
        wait_nxt = wait_cnt + 1'b1;
    end

    // Purpose: remember the enable level; reset high so a level is no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= en_lvl;
    end

    // Purpose: state transitions and the start-up wait timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            wait_cnt <= '0;
        end else begin
            case (state)
                ST_OFF: begin
                    wait_cnt <= '0;
                    if (en_rise) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (expire) begin
                        state <= ST_SHUT;
                    end else if (hold) begin
                        state <= ST_ON;
                    end else if (tick) begin
                        if (wait_nxt >= WAIT_LIM) state <= ST_SHUT;
                        else                      wait_cnt <= wait_nxt;
                    end
                end
                ST_ON: begin
                    if (expire || (!hold && !lpm)) state <= ST_SHUT;
                end
                default: state <= ST_OFF;
            endcase
        end
    end

endmodule

// File: rtl/lpsd_chan_drv.sv
// Output stage: decodes the registered state into reset output, channel
// enables and per-channel discharge. Assumes state is a register.
module lpsd_chan_drv
    import lpsd_pkg::*;
#(
    parameter int NCH = 4
) (
    input  sup_state_t     state,
    input  logic [NCH-1:0] dis_cfg,
    output logic           rst_out_n,
    output logic [NCH-1:0] ch_en,
    output logic [NCH-1:0] ch_dis
);

    logic powered;

    // Purpose: reset released only in start-up wait and on.
    assign rst_out_n = (state == ST_WAIT) || (state == ST_ON);
    // Purpose: channels stay up through the shutdown state.
    assign powered   = (state != ST_OFF);

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        // Purpose: channel enable and its discharge, mutually exclusive.
        assign ch_en[i]  = powered;
        assign ch_dis[i] = !powered && dis_cfg[i];
    end

endmodule

// File: rtl/lp_shutdown_ctrl.sv
// Top: long-press enable shutdown supervisor. Combines timeout decode,
// the long-press monitor, the sequencer and the channel output stage.
// Assumes all inputs are synchronous to clk and tick_ms is a 1-cycle pulse.
module lp_shutdown_ctrl
    import lpsd_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int STARTUP_MS = 100,
    parameter int STAT_W     = 8,
    parameter int STAT_BIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              hold_in,
    input  logic              lpm_in,
    input  logic              tick_ms,
    input  logic              stat_rd,
    input  logic [1:0]        t8_sel,
    input  logic [1:0]        t9_sel,
    input  logic [NCH-1:0]    dis_cfg,
    output logic              irq_n,
    output logic [STAT_W-1:0] stat_word,
    output logic              rst_out_n,
    output logic [NCH-1:0]    ch_en,
    output logic [NCH-1:0]    ch_dis
);

    sup_state_t       state;
    logic [TMR_W-1:0] lim_press;
    logic [TMR_W-1:0] lim_resp;
    logic             mon_active;
    logic             pend;
    logic             expire;

    // Purpose: monitor runs only while the supply is up and not shutting down.
    assign mon_active = (state == ST_WAIT) || (state == ST_ON);

    lpsd_timeout_sel u_sel (
        .t8_sel    (t8_sel),
        .t9_sel    (t9_sel),
        .lim_press (lim_press),
        .lim_resp  (lim_resp)
    );

    lpsd_press_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (mon_active),
        .en_lvl    (pwr_en),
        .tick      (tick_ms),
        .ack_rd    (stat_rd),
        .lim_press (lim_press),
        .lim_resp  (lim_resp),
        .pend      (pend),
        .expire    (expire)
    );

    lpsd_seq_fsm #(.STARTUP_MS(STARTUP_MS)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_lvl (pwr_en),
        .hold   (hold_in),
        .lpm    (lpm_in),
        .tick   (tick_ms),
        .expire (expire),
        .state  (state)
    );

    lpsd_chan_drv #(.NCH(NCH)) u_drv (
        .state     (state),
        .dis_cfg   (dis_cfg),
        .rst_out_n (rst_out_n),
        .ch_en     (ch_en),
        .ch_dis    (ch_dis)
    );

    // Purpose: interrupt pin and status word carry the pending flag.
    assign irq_n = !pend;
    always_comb begin
        stat_word           = '0;
        stat_word[STAT_BIT] = pend;
    end

endmodule

// File: rtl/lpsd_checker.sv
// Checker: port-level temporal properties of the shutdown supervisor.
// Bound to every instance of the top module.
module lpsd_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pwr_en,
    input logic           stat_rd,
    input logic [NCH-1:0] dis_cfg,
    input logic           irq_n,
    input logic           rst_out_n,
    input logic [NCH-1:0] ch_en,
    input logic [NCH-1:0] ch_dis
);

    // R4 / R8: channels only drop after reset output was already low
    p_reset_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == '0 && $past(ch_en) != '0) |-> !$past(rst_out_n));

    // R10: discharge follows configuration whenever channels are off
    p_dis_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == '0) |-> (ch_dis == dis_cfg));

    // R10: no discharge while any channel is enabled
    p_dis_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en != '0) |-> (ch_dis == '0));

    // R7: a read while the interrupt is pending releases it next cycle
    p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && stat_rd) |=> irq_n);

    // R5: the interrupt only falls after an edge that saw enable low
    p_irq_low_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> !$past(pwr_en));

    // R2 / R11: channels switch on only after a rising enable edge
    p_start_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ch_en) == '0 && ch_en != '0) |-> ($past(pwr_en) && !$past(pwr_en, 2)));

endmodule

bind lp_shutdown_ctrl lpsd_checker #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_en    (pwr_en),
    .stat_rd   (stat_rd),
    .dis_cfg   (dis_cfg),
    .irq_n     (irq_n),
    .rst_out_n (rst_out_n),
    .ch_en     (ch_en),
    .ch_dis    (ch_dis)
);

// File: tb/lp_shutdown_ctrl_tb.sv
// Bench for the long-press shutdown supervisor: a table of timeout codes
// walked by one loop, then directed scenarios. Tick is driven every cycle.
module lp_shutdown_ctrl_tb;

    localparam int NCH     = 4;
    localparam int SU_MS   = 300;
    localparam int SB      = 5;
    localparam logic [NCH-1:0] CFG = 4'b1010;

    typedef struct packed {
        logic [1:0] c8;
        logic [1:0] c9;
        int         n8;
        int         n9;
    } vec_t;

    // Enable timeout ticks to interrupt and response ticks to reset (R6, R8)
    localparam vec_t VECS [4] = '{
        '{2'b00, 2'b00, 1,    100},
        '{2'b01, 2'b01, 4000, 500},
        '{2'b10, 2'b10, 2000, 1000},
        '{2'b11, 2'b11, 8000, 2000}
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           pwr_en, hold_in, lpm_in, tick_ms, stat_rd;
    logic [1:0]     t8_sel, t9_sel;
    logic [NCH-1:0] dis_cfg;
    logic           irq_n, rst_out_n;
    logic [7:0]     stat_word;
    logic [NCH-1:0] ch_en, ch_dis;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lp_shutdown_ctrl #(.NCH(NCH), .STARTUP_MS(SU_MS)) u_dut (
        .clk (clk), .rst_n (rst_n), .pwr_en (pwr_en), .hold_in (hold_in),
        .lpm_in (lpm_in), .tick_ms (tick_ms), .stat_rd (stat_rd),
        .t8_sel (t8_sel), .t9_sel (t9_sel), .dis_cfg (dis_cfg),
        .irq_n (irq_n), .stat_word (stat_word), .rst_out_n (rst_out_n),
        .ch_en (ch_en), .ch_dis (ch_dis)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance n edges, then settle past the edge before sampling or driving.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Rising enable edge with power-hold high: start-up wait, then on.
    task automatic power_up();
        hold_in = 1'b1; lpm_in = 1'b0;
        pwr_en = 1'b0; step(1);
        pwr_en = 1'b1; step(2);
    endtask

    task automatic ack();
        stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        step(100000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; pwr_en = 1'b1; hold_in = 1'b0; lpm_in = 1'b0;
        tick_ms = 1'b1; stat_rd = 1'b0; t8_sel = 2'b01; t9_sel = 2'b01;
        dis_cfg = CFG;
        step(3);
        // R1: reset state
        check("R1 rst_out_n", rst_out_n, 0);
        check("R1 ch_en", ch_en, 0);
        check("R1 irq_n", irq_n, 1);
        check("R1 stat_word", stat_word, 0);
        check("R1 ch_dis", ch_dis, CFG);
        rst_n = 1'b1;
        hold_in = 1'b1;
        step(5);
        // R2/R11: enable high from reset is no rising edge
        check("R11 stays off with steady enable", ch_en, 0);

        // Table: each timeout code pair through a full autonomous shutdown
        foreach (VECS[i]) begin
            t8_sel = VECS[i].c8; t9_sel = VECS[i].c9;
            power_up();
            check("R2 channels on", ch_en, 4'hF);
            check("R10 no discharge while on", ch_dis, 0);
            pwr_en = 1'b0;
            step(VECS[i].n8 - 1);
            check("R6 irq before enable limit", irq_n, 1);
            step(1);
            check("R5/R6 irq at enable limit", irq_n, 0);
            check("R5 status bit 5", stat_word[SB], 1);
            step(VECS[i].n9 - 1);
            check("R8 reset held before response limit", rst_out_n, 1);
            step(1);
            check("R8 reset low at response limit", rst_out_n, 0);
            check("R8 channels still on during shutdown", ch_en, 4'hF);
            step(1);
            check("R8 channels off", ch_en, 0);
            check("R10 discharge per config", ch_dis, CFG);
        end

        // R3: start-up wait times out without power-hold
        t8_sel = 2'b11; t9_sel = 2'b11;
        hold_in = 1'b0; lpm_in = 1'b0;
        pwr_en = 1'b0; step(1); pwr_en = 1'b1; step(1);
        check("R2 start-up wait releases reset", rst_out_n, 1);
        step(SU_MS - 1);
        check("R3 still waiting before start-up limit", rst_out_n, 1);
        step(1);
        check("R3 shutdown at start-up limit", rst_out_n, 0);
        step(1);
        check("R3 off after start-up timeout", ch_en, 0);

        // R3: power-hold in start-up wait moves to on
        pwr_en = 1'b0; step(1); pwr_en = 1'b1; step(1);
        hold_in = 1'b1; step(SU_MS + 20);
        check("R3 on after power-hold", rst_out_n, 1);

        // R4: low-power request blocks host shutdown
        lpm_in = 1'b1; hold_in = 1'b0; step(5);
        check("R4 low-power blocks shutdown", rst_out_n, 1);
        lpm_in = 1'b0; step(1);
        check("R4 reset low after hold drop", rst_out_n, 0);
        check("R4 channels on one more cycle", ch_en, 4'hF);
        step(1);
        check("R4 channels off", ch_en, 0);
        hold_in = 1'b1; step(10);
        check("R11 hold does not restart", ch_en, 0);

        // R7: acknowledge extends the press, then release keeps running
        t8_sel = 2'b10; t9_sel = 2'b11;
        power_up();
        pwr_en = 1'b0; step(2000);
        check("R5 irq after 2000 ticks", irq_n, 0);
        step(100);
        check("R7 status bit visible before read", stat_word[SB], 1);
        ack();
        check("R7 irq released by read", irq_n, 1);
        check("R7 status bit cleared by read", stat_word[SB], 0);
        step(1999);
        check("R7 press count restarted", irq_n, 1);
        step(1);
        check("R7 irq again after restart", irq_n, 0);
        ack();
        pwr_en = 1'b1; step(3000);
        check("R7 no shutdown after release", rst_out_n, 1);
        check("R7 irq stays high after release", irq_n, 1);

        // R6: a high enable sample restarts the press count
        pwr_en = 1'b0; step(1500);
        pwr_en = 1'b1; step(1);
        pwr_en = 1'b0; step(1999);
        check("R6 count restarted by enable high", irq_n, 1);
        step(1);
        check("R6 irq after full count", irq_n, 0);
        ack();

        // R12: read on the expiry edge wins
        t8_sel = 2'b00; t9_sel = 2'b00;
        pwr_en = 1'b1; step(1);
        pwr_en = 1'b0; step(1);
        check("R6 zero timeout fires on first tick", irq_n, 0);
        step(99);
        ack();
        check("R12 read on expiry edge prevents shutdown", rst_out_n, 1);
        check("R12 irq released", irq_n, 1);

        // R9: response expiry during start-up wait
        hold_in = 1'b0; lpm_in = 1'b0; step(2);
        check("R4 off before start-up test", ch_en, 0);
        pwr_en = 1'b0; step(1); pwr_en = 1'b1; step(1);
        pwr_en = 1'b0; step(100);
        check("R9 still in start-up wait", rst_out_n, 1);
        step(1);
        check("R9 expiry abandons start-up wait", rst_out_n, 0);
        step(1);
        check("R9 off after expiry", ch_en, 0);
        hold_in = 1'b1; step(20);
        check("R11 low enable keeps off", ch_en, 0);
        pwr_en = 1'b1; step(1);
        check("R11 new rising edge restarts", ch_en, 4'hF);

        finish_run();
    end

endmodule